// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

The block multiplies two WIDTH-bit operands over WIDTH clock cycles and returns a double-width product as two WIDTH-bit words. A single WIDTH-bit adder does all the work. The multiplier operand is loaded into the lower half of a double-width product register, with the upper half cleared. On each step, the register's lowest bit decides whether the multiplicand is added into the upper half. The whole register, including the adder's carry-out, then moves one place right. In this way the multiplier bits are used up as the partial product grows into the space they leave behind.

A select input chooses unsigned or two's-complement operation. In signed mode both operands are converted to magnitudes before the loop starts. The unsigned result is negated at the end when the operand signs differ. The most negative operand works correctly because its magnitude fits as an unsigned WIDTH-bit value. A caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse and reads `prod_hi` and `prod_lo`. These two outputs keep their value until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `busy`, `done`, `prod_hi` and `prod_lo` are all zero.
- R2: A `start` sampled high on a clock edge while `busy` is low is accepted: `busy` is high after that edge.
- R3: With `is_signed` low, {`prod_hi`,`prod_lo`} equals the unsigned product of `mcand` and `mplier`. `prod_hi` carries bits 2*WIDTH-1..WIDTH and `prod_lo` carries bits WIDTH-1..0.
- R4: With `is_signed` high, {`prod_hi`,`prod_lo`} equals the two's-complement product. This includes operands equal to the most negative value, zero, and all ones (minus one).
- R5: `done` is high after exactly WIDTH clock edges following the accepting edge. `busy` stays high through the WIDTH steps and is low in the cycle in which `done` is high.
- R6: A `start` that arrives while `busy` is high has no effect. The result and the latency are those of the operation already in progress.
- R7: `done` is high for exactly one cycle. `prod_hi` and `prod_lo` do not change from the `done` cycle until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | WIDTH | Multiplicand |
| mplier | input | WIDTH | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | WIDTH | Upper word of the product |
| prod_lo | output | WIDTH | Lower word of the product |

## Verification
Assertions check the control behaviour on every cycle:
- acceptance of a start while idle;
- the single-cycle `done` pulse, which must come straight out of a busy period;
- the step counter staying in range;
- the outputs staying stable whenever the block is idle;
- a start during busy leaving the block busy or finishing.

Only the bench's scenarios can show that the arithmetic is correct. It sweeps every operand pair in both modes on a 4-bit instance. On the 32-bit instance it covers the most negative, zero and all-ones operands, measures the latency edge by edge, and confirms that a start injected mid-operation leaves the product untouched.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);
  localparam int PW = 2 * WIDTH;
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [PW-1:0]    acc;
  logic [WIDTH-1:0] mc_q;
  logic [CW-1:0]    step;
  logic             neg_q;

  wire accept = start && !busy;
  wire a_neg  = is_signed && mcand[WIDTH-1];
  wire b_neg  = is_signed && mplier[WIDTH-1];
  wire [WIDTH-1:0] a_mag = a_neg ? -mcand  : mcand;
  wire [WIDTH-1:0] b_mag = b_neg ? -mplier : mplier;

  wire [WIDTH:0]  sum  = {1'b0, acc[PW-1:WIDTH]} + {1'b0, acc[0] ? mc_q : '0};
  wire [PW-1:0]   nxt  = {sum, acc[WIDTH-1:1]};
  wire [PW-1:0]   fin  = neg_q ? -nxt : nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      mc_q    <= '0;
      step    <= '0;
      neg_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      prod_hi <= '0;
      prod_lo <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        acc   <= {{WIDTH{1'b0}}, b_mag};
        mc_q  <= a_mag;
        neg_q <= a_neg ^ b_neg;
        step  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc  <= nxt;
        step <= step + 1'b1;
        if (step == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          prod_hi <= fin[PW-1:WIDTH];
          prod_lo <= fin[WIDTH-1:0];
        end
      end
    end
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R5
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= LAST)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({prod_hi, prod_lo})); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R6
endmodule

// File: tb/seq_mul_test.sv
module seq_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        start = 0, sgn = 0;
  logic [31:0] a = 0, b = 0;
  logic        busy, done;
  logic [31:0] hi, lo;

  logic        s_start = 0, s_sgn = 0;
  logic [3:0]  sa = 0, sb = 0;
  logic        s_busy, s_done;
  logic [3:0]  s_hi, s_lo;

  seq_mul #(.WIDTH(32)) uut (.clk(clk), .rst_n(rst_n), .start(start), .is_signed(sgn),
    .mcand(a), .mplier(b), .busy(busy), .done(done), .prod_hi(hi), .prod_lo(lo));

  seq_mul #(.WIDTH(4)) uut_small (.clk(clk), .rst_n(rst_n), .start(s_start), .is_signed(s_sgn),
    .mcand(sa), .mplier(sb), .busy(s_busy), .done(s_done), .prod_hi(s_hi), .prod_lo(s_lo));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref32(input bit s, input logic [31:0] x, input logic [31:0] y);
    if (s) return 64'($signed(x) * $signed(y));
    return {32'd0, x} * {32'd0, y};
  endfunction

  task automatic run32(input bit s, input logic [31:0] x, input logic [31:0] y, input bit poke);
    int k = 0;
    logic [63:0] exp = ref32(s, x, y);
    @(negedge clk);
    sgn = s; a = x; b = y; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R2", {63'd0, busy}, 64'd1);
    k = 1;
    while (done !== 1'b1 && k < 200) begin
      if (poke && k == 10) begin
        start = 1; a = ~x; b = 32'h5; sgn = ~s;
      end else start = 0;
      @(negedge clk);
      k++;
      if (done !== 1'b1 && k <= 32)
        check(busy === 1'b1, "R5 busy", {63'd0, busy}, 64'd1);
    end
    start = 0;
    if (k >= 200) check(0, "R5 watchdog", 64'(k), 64'd33);
    check(k == 33, poke ? "R6 latency" : "R5 latency", 64'(k), 64'd33);
    check(busy === 1'b0, "R5 busy low at done", {63'd0, busy}, 64'd0);
    check({hi, lo} === exp, poke ? "R6" : (s ? "R4" : "R3"), {hi, lo}, exp);
    @(negedge clk);
    check(done === 1'b0, "R7 pulse", {63'd0, done}, 64'd0);
    a = 32'h1234_5678; b = 32'h9abc_def0;
    repeat (3) @(negedge clk);
    check({hi, lo} === exp, "R7 hold", {hi, lo}, exp);
  endtask

  task automatic run4(input bit s, input logic [3:0] x, input logic [3:0] y);
    int k = 0;
    logic [7:0] exp;
    exp = s ? 8'($signed({{4{x[3]}}, x}) * $signed({{4{y[3]}}, y})) : {4'd0, x} * {4'd0, y};
    @(negedge clk);
    s_sgn = s; sa = x; sb = y; s_start = 1;
    @(negedge clk);
    s_start = 0;
    k = 1;
    while (s_done !== 1'b1 && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(k == 5, "R5 small latency", 64'(k), 64'd5);
    check({s_hi, s_lo} === exp, s ? "R4 sweep" : "R3 sweep", 64'({s_hi, s_lo}), 64'(exp));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, hi, lo} === '0, "R1 in reset", {hi, lo}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check({busy, done, hi, lo} === '0, "R1 after release", {hi, lo}, 64'd0);
    check({s_busy, s_done, s_hi, s_lo} === '0, "R1 small", 64'({s_hi, s_lo}), 64'd0);

    run32(0, 32'd6, 32'd5, 0);
    run32(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run32(0, 32'h8000_0000, 32'h8000_0000, 0);
    run32(0, 32'd0, 32'hDEAD_BEEF, 0);
    run32(0, 32'hFFFF_FFFF, 32'd0, 0);
    run32(0, 32'h1234_5678, 32'h8765_4321, 0);
    run32(1, 32'h8000_0000, 32'h8000_0000, 0);
    run32(1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run32(1, 32'h8000_0000, 32'd1, 0);
    run32(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run32(1, 32'd0, 32'h8000_0000, 0);
    run32(1, 32'hFFFF_FFF9, 32'd13, 0);
    run32(1, 32'h7FFF_FFFF, 32'h8000_0001, 0);
    run32(0, 32'hCAFE_0001, 32'h0003_0007, 1);
    run32(1, 32'hF000_0003, 32'h0000_0123, 1);

    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run4(m[0], 4'(x), 4'(y));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule